// File: doc/BRIEF.md
# Data-Tenure Termination Controller

This block sits on the memory side of a processor bus whose address and data phases are split, and it decides when and how each data phase ends. A transfer-start strobe opens a tenure and carries the transfer's attributes: burst or single beat, read or write, data-cache or instruction fetch, and cacheable or not. The controller issues a one-cycle data-bus grant and then one acknowledge per beat as the memory hands beats over through a ready/valid handshake. A beat the memory flags as faulty is answered with a one-cycle transfer-error instead, and the tenure ends there.

Two static inputs set the processor-to-bus clock ratio and whether the data-retry mechanism is disabled. Cacheable burst reads into the data cache at the two fastest ratios need a forced gap before their first acknowledge. That gap is one wait state, or two when data-retry is disabled. A third static input chooses whether the gap comes from holding the acknowledge back or from holding the grant back. Each accepted tenure receives a tag equal to its start order. An address retry carrying the current tag aborts the tenure at once. A retry carrying any other tag is ignored.

Top module: `dtenure_term_ctl`

## Requirements
- R1: A transfer-start strobe is accepted only while no tenure is active; a strobe during an active tenure is ignored. Accepted tenures are tagged 0, 1, 2, … in start order, modulo 2^TAG_W, and the count restarts at 0 after reset.
- R2: With `cfg_ratio` 0 (1:1) or 1 (1.5:1), a cacheable burst read into the data cache gets its first acknowledge no earlier than the second cycle after the start-strobe cycle (one wait state).
- R3: Under the conditions of R2 with `cfg_no_dretry` high, the first acknowledge comes no earlier than the third cycle after the start-strobe cycle (two wait states).
- R4: Instruction fetches, writes, noncacheable reads, single-beat transfers, and every transfer at `cfg_ratio` 2 or 3 may be acknowledged in the cycle right after the start strobe.
- R5: No acknowledge or error for a tenure is ever issued earlier than ARTRY_WIN cycles after its start-strobe cycle.
- R6: `data_grant` is high for exactly one cycle per tenure. With `cfg_hold_grant` low it comes in the cycle after the start strobe. With `cfg_hold_grant` high it comes in the first cycle in which an acknowledge is permitted. No acknowledge precedes the grant.
- R7: `mem_ready` is high exactly in the cycles of an active tenure in which a beat may be acknowledged. A beat is taken in any cycle where both `mem_valid` and `mem_ready` are high.
- R8: A beat taken with `mem_err` low raises `xfer_ack` in that same cycle. A single-beat tenure ends after one acknowledge, and a burst tenure ends after BEATS acknowledges (4 by default).
- R9: A beat taken with `mem_err` high raises `xfer_err` instead of `xfer_ack` for that cycle, and the tenure ends.
- R10: When `addr_retry_vld` is high with `addr_retry_tag` equal to the active tenure's tag, `mem_ready`, `xfer_ack` and `xfer_err` are low in that cycle, and the tenure ends. It issues nothing more.
- R11: An address retry whose tag differs from the active tenure's tag has no effect on that tenure.
- R12: `data_retry` is never asserted. `xfer_err` stays low throughout any tenure whose beats all return without error.
- R13: During and right after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Transfer-start strobe, one cycle |
| xfer_burst | input | 1 | Attribute: 1 = burst, 0 = single beat |
| xfer_read | input | 1 | Attribute: 1 = read, 0 = write |
| xfer_dcache | input | 1 | Attribute: 1 = data-cache access, 0 = instruction fetch |
| xfer_cacheable | input | 1 | Attribute: 1 = cacheable |
| cfg_ratio | input | 2 | Clock ratio: 0 = 1:1, 1 = 1.5:1, 2 = 2:1, 3 = other |
| cfg_no_dretry | input | 1 | Data-retry disabled mode |
| cfg_hold_grant | input | 1 | 1 = insert the gap by delaying the grant, 0 = by delaying the acknowledge |
| addr_retry_vld | input | 1 | Address retry present |
| addr_retry_tag | input | TAG_W | Start-order tag of the address tenure being retried |
| mem_valid | input | 1 | Memory presents a beat |
| mem_err | input | 1 | Presented beat is faulty |
| mem_ready | output | 1 | Controller can take a beat this cycle |
| data_grant | output | 1 | One-cycle data-bus grant |
| xfer_ack | output | 1 | Transfer acknowledge, one per good beat |
| xfer_err | output | 1 | Transfer error, ends the tenure |
| data_retry | output | 1 | Data retry, held negated |

## Verification
The hardest situation to reach is an address retry that lands in the middle of a burst. It must be told apart from a retry aimed at an earlier tenure, and that requires the bench to know which tag the controller gave the active tenure. The bench keeps its own start-order count in its reference model. It fires the retry at a chosen cycle after the strobe, carrying either the live tag or the previous one. It then counts how many acknowledges escaped before the kill. A second strobe is also injected in the middle of a burst, and the bench confirms that it neither raises a second grant nor advances the tag count.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

    typedef enum logic [1:0] {
        RATIO_1_1   = 2'd0,
        RATIO_3_2   = 2'd1,
        RATIO_2_1   = 2'd2,
        RATIO_OTHER = 2'd3
    } clk_ratio_e;

    typedef struct packed {
        logic burst;
        logic read;
        logic dcache;
        logic cacheable;
    } xfer_attr_t;

    typedef struct packed {
        logic busy;
        logic granted;
        logic burst;
    } tenure_ctx_t;

    // Wait states forced before the first acknowledge, from transfer kind and ratio.
    function automatic logic [1:0] forced_waits(input xfer_attr_t a,
                                                input clk_ratio_e r,
                                                input logic no_dretry);
        logic fast_ratio;
        fast_ratio = (r == RATIO_1_1) || (r == RATIO_3_2);
        if (fast_ratio && a.burst && a.read && a.dcache && a.cacheable)
            return no_dretry ? 2'd2 : 2'd1;
        return 2'd0;
    endfunction

endpackage

// File: rtl/dtt_gap_policy.sv
module dtt_gap_policy
    import dtt_pkg::*;
#(
    parameter int unsigned ARTRY_WIN = 1,
    parameter int unsigned CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  xfer_attr_t       attr,
    input  clk_ratio_e       ratio,
    input  logic             no_dretry,
    output logic [CNT_W-1:0] first_ack_off
);

    logic [CNT_W-1:0] from_waits;
    logic [CNT_W-1:0] from_window;

    always_comb begin
        from_waits    = CNT_W'(forced_waits(attr, ratio, no_dretry)) + CNT_W'(1);
        from_window   = CNT_W'(ARTRY_WIN);
        first_ack_off = (from_window > from_waits) ? from_window : from_waits;
    end

    logic dc_burst_fast;
    assign dc_burst_fast = (ratio == RATIO_1_1 || ratio == RATIO_3_2) &&
                           attr.burst && attr.read && attr.dcache && attr.cacheable;

    AST_ONE_WAIT_MIN: assert property (@(posedge clk) disable iff (rst)
        dc_burst_fast |-> (first_ack_off >= CNT_W'(2)));            // R2
    AST_TWO_WAIT_MIN: assert property (@(posedge clk) disable iff (rst)
        (dc_burst_fast && no_dretry) |-> (first_ack_off >= CNT_W'(3))); // R3
    AST_WINDOW_MIN: assert property (@(posedge clk) disable iff (rst)
        first_ack_off >= CNT_W'(ARTRY_WIN));                        // R5

endmodule

// File: rtl/dtt_beat_ctr.sv
module dtt_beat_ctr #(
    parameter int unsigned BEATS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    input  logic is_burst,
    output logic last
);

    localparam int unsigned BW = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + BW'(1);
        end
    end

    assign last = !is_burst || (cnt_q == BW'(BEATS - 1));

    AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= BW'(BEATS - 1));                                   // R8

endmodule

// File: rtl/dtenure_term_ctl.sv
module dtenure_term_ctl
    import dtt_pkg::*;
#(
    parameter int unsigned BEATS     = 4,
    parameter int unsigned ARTRY_WIN = 1,
    parameter int unsigned TAG_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_start,
    input  logic             xfer_burst,
    input  logic             xfer_read,
    input  logic             xfer_dcache,
    input  logic             xfer_cacheable,
    input  logic [1:0]       cfg_ratio,
    input  logic             cfg_no_dretry,
    input  logic             cfg_hold_grant,
    input  logic             addr_retry_vld,
    input  logic [TAG_W-1:0] addr_retry_tag,
    input  logic             mem_valid,
    input  logic             mem_err,
    output logic             mem_ready,
    output logic             data_grant,
    output logic             xfer_ack,
    output logic             xfer_err,
    output logic             data_retry
);

    localparam int unsigned OFF_MAX = (ARTRY_WIN > 3) ? ARTRY_WIN : 3;
    localparam int unsigned CNT_W   = $clog2(OFF_MAX + 1) + 1;

    xfer_attr_t       attr_in;
    logic [CNT_W-1:0] off_in;

    tenure_ctx_t      ctx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] off_q;
    logic [TAG_W-1:0] cur_tag_q;
    logic [TAG_W-1:0] tag_ctr_q;

    logic accept, kill, gap_ok, beat, last_beat, tenure_end;

    assign attr_in = '{burst: xfer_burst, read: xfer_read,
                       dcache: xfer_dcache, cacheable: xfer_cacheable};

    dtt_gap_policy #(.ARTRY_WIN(ARTRY_WIN), .CNT_W(CNT_W)) policy_i (
        .clk           (clk),
        .rst           (rst),
        .attr          (attr_in),
        .ratio         (clk_ratio_e'(cfg_ratio)),
        .no_dretry     (cfg_no_dretry),
        .first_ack_off (off_in)
    );

    always_comb begin
        accept     = xfer_start && !ctx_q.busy;
        kill       = ctx_q.busy && addr_retry_vld && (addr_retry_tag == cur_tag_q);
        gap_ok     = cnt_q >= off_q;
        data_grant = ctx_q.busy && !ctx_q.granted && (cfg_hold_grant ? gap_ok : 1'b1);
        mem_ready  = ctx_q.busy && gap_ok && !kill;
        beat       = mem_ready && mem_valid;
        xfer_ack   = beat && !mem_err;
        xfer_err   = beat && mem_err;
        data_retry = 1'b0;
        tenure_end = kill || xfer_err || (xfer_ack && last_beat);
    end

    dtt_beat_ctr #(.BEATS(BEATS)) beats_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept || tenure_end),
        .step     (xfer_ack),
        .is_burst (ctx_q.burst),
        .last     (last_beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q     <= '0;
            cnt_q     <= '0;
            off_q     <= '0;
            cur_tag_q <= '0;
            tag_ctr_q <= '0;
        end else if (accept) begin
            ctx_q     <= '{busy: 1'b1, granted: 1'b0, burst: xfer_burst};
            cnt_q     <= CNT_W'(1);
            off_q     <= off_in;
            cur_tag_q <= tag_ctr_q;
            tag_ctr_q <= tag_ctr_q + TAG_W'(1);
        end else if (ctx_q.busy) begin
            if (tenure_end) begin
                ctx_q.busy <= 1'b0;
            end
            if (data_grant) begin
                ctx_q.granted <= 1'b1;
            end
            if (cnt_q < CNT_W'(OFF_MAX)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(xfer_ack && xfer_err));                                   // R9
    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst)
        data_grant |=> !data_grant);                                // R6
    AST_ACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |-> (ctx_q.granted || data_grant));                // R6
    AST_KILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        kill |=> !(xfer_ack || xfer_err || data_grant || mem_ready)); // R10
    AST_FIRST_ACK_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (xfer_ack || xfer_err) |-> (cnt_q >= CNT_W'(ARTRY_WIN)));   // R5
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.busy && !tenure_end) |=> $stable(cur_tag_q));        // R1

endmodule

// File: tb/dtenure_term_ctl_tb_top.sv
module dtenure_term_ctl_tb_top;

    localparam int BEATS = 4;
    localparam int WIN   = 1;
    localparam int TAG_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xfer_start = 0, xfer_burst = 0, xfer_read = 0, xfer_dcache = 0, xfer_cacheable = 0;
    logic [1:0] cfg_ratio = 2'd0;
    logic cfg_no_dretry = 0, cfg_hold_grant = 0;
    logic addr_retry_vld = 0;
    logic [TAG_W-1:0] addr_retry_tag = '0;
    logic mem_valid = 0, mem_err = 0;
    logic mem_ready, data_grant, xfer_ack, xfer_err, data_retry;

    always #2.5 clk = ~clk;

    dtenure_term_ctl #(.BEATS(BEATS), .ARTRY_WIN(WIN), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_burst(xfer_burst),
        .xfer_read(xfer_read), .xfer_dcache(xfer_dcache), .xfer_cacheable(xfer_cacheable),
        .cfg_ratio(cfg_ratio), .cfg_no_dretry(cfg_no_dretry), .cfg_hold_grant(cfg_hold_grant),
        .addr_retry_vld(addr_retry_vld), .addr_retry_tag(addr_retry_tag),
        .mem_valid(mem_valid), .mem_err(mem_err), .mem_ready(mem_ready),
        .data_grant(data_grant), .xfer_ack(xfer_ack), .xfer_err(xfer_err),
        .data_retry(data_retry)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    bit m_busy = 0, m_granted = 0, m_burst = 0;
    int m_cnt = 0, m_off = 0, m_beats = 0, m_cur = 0, m_tagctr = 0;
    bit e_kill, e_grant, e_ready, e_ack, e_err;

    // per-tenure observations
    int ts_cyc = 0, n_grant = 0, n_ack = 0, n_err = 0, first_ack = -1, grant_at = -1;

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int calc_off(bit b, bit r, bit d, bit c, int ratio, bit nodr);
        int w;
        w = ((ratio <= 1) && b && r && d && c) ? (nodr ? 2 : 1) : 0;
        return (WIN > 1 + w) ? WIN : 1 + w;
    endfunction

    always @(negedge clk) begin
        e_kill  = m_busy && addr_retry_vld && (int'(addr_retry_tag) == m_cur);
        e_grant = m_busy && !m_granted && (cfg_hold_grant ? (m_cnt >= m_off) : 1'b1);
        e_ready = m_busy && (m_cnt >= m_off) && !e_kill;
        e_ack   = e_ready && mem_valid && !mem_err;
        e_err   = e_ready && mem_valid && mem_err;
        if (!rst) begin
            chk("R6",  int'(data_grant), int'(e_grant), "data_grant");
            chk("R7",  int'(mem_ready),  int'(e_ready), "mem_ready");
            chk("R8",  int'(xfer_ack),   int'(e_ack),   "xfer_ack");
            chk("R9",  int'(xfer_err),   int'(e_err),   "xfer_err");
            chk("R12", int'(data_retry), 0,             "data_retry");
            if (data_grant) begin
                n_grant++;
                if (grant_at < 0) grant_at = cyc - ts_cyc;
            end
            if (xfer_ack) begin
                n_ack++;
                if (first_ack < 0) first_ack = cyc - ts_cyc;
            end
            if (xfer_err) n_err++;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_busy = 0; m_granted = 0; m_cnt = 0; m_tagctr = 0; m_cur = 0; m_beats = 0;
        end else if (!m_busy) begin
            if (xfer_start) begin
                m_busy = 1; m_granted = 0; m_cnt = 1; m_beats = 0; m_burst = xfer_burst;
                m_off = calc_off(xfer_burst, xfer_read, xfer_dcache, xfer_cacheable,
                                 int'(cfg_ratio), cfg_no_dretry);
                m_cur = m_tagctr;
                m_tagctr = (m_tagctr + 1) % (1 << TAG_W);
            end
        end else if (e_kill) begin
            m_busy = 0;
        end else begin
            if (e_grant) m_granted = 1;
            if (e_ack) begin
                m_beats++;
                if (!m_burst || m_beats == BEATS) m_busy = 0;
            end
            if (e_err) m_busy = 0;
            m_cnt++;
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tenure(input bit b, input bit r, input bit d, input bit c,
                          input int ratio, input bit nodr, input bit hold,
                          input int vevery, input int err_rel, input int kill_rel,
                          input bit kill_old, input int extra_ts_rel);
        @(posedge clk); #1;
        xfer_burst = b; xfer_read = r; xfer_dcache = d; xfer_cacheable = c;
        cfg_ratio = 2'(ratio); cfg_no_dretry = nodr; cfg_hold_grant = hold;
        xfer_start = 1; mem_valid = 1; mem_err = 0; addr_retry_vld = 0;
        ts_cyc = cyc; n_grant = 0; n_ack = 0; n_err = 0; first_ack = -1; grant_at = -1;
        for (int k = 1; k <= 16; k++) begin
            @(posedge clk); #1;
            xfer_start = (k == extra_ts_rel);
            mem_valid = (vevery == 1) || (k % vevery == 0);
            mem_err = (k == err_rel);
            addr_retry_vld = (k == kill_rel);
            addr_retry_tag = kill_old ? TAG_W'(m_cur - 1) : TAG_W'(m_cur);
        end
        xfer_start = 0; mem_valid = 0; mem_err = 0; addr_retry_vld = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: outputs low in reset
        chk("R13", int'({mem_ready, data_grant, xfer_ack, xfer_err, data_retry}), 0, "outputs in reset");
        @(posedge clk); #1; rst = 0;
        @(negedge clk);
        chk("R13", int'({mem_ready, data_grant, xfer_ack, xfer_err, data_retry}), 0, "outputs after reset");

        // R4: single-beat cacheable dcache read at 1:1, no forced wait
        tenure(0,1,1,1, 0,0,0, 1, -1,-1,0,-1);
        chk("R4", first_ack, 1, "single-beat first ack");
        chk("R8", n_ack, 1, "single-beat ack count");
        chk("R12", n_err, 0, "no error on clean single beat");

        // R2: burst dcache read at 1:1
        tenure(1,1,1,1, 0,0,0, 1, -1,-1,0,-1);
        chk("R2", first_ack, 2, "1:1 burst first ack");
        chk("R8", n_ack, 4, "burst ack count");
        // R2: at 1.5:1
        tenure(1,1,1,1, 1,0,0, 1, -1,-1,0,-1);
        chk("R2", first_ack, 2, "1.5:1 burst first ack");
        // R3: two waits with data-retry disabled
        tenure(1,1,1,1, 0,1,0, 1, -1,-1,0,-1);
        chk("R3", first_ack, 3, "no-dretry burst first ack");
        chk("R6", grant_at, 1, "grant in cycle after strobe");
        // R6: grant-hold variant
        tenure(1,1,1,1, 1,1,1, 1, -1,-1,0,-1);
        chk("R6", grant_at, 3, "held grant position");
        chk("R6", n_grant, 1, "single grant");
        chk("R3", first_ack, 3, "held grant first ack");

        // R4: exempt kinds
        tenure(1,1,1,1, 2,1,0, 1, -1,-1,0,-1);
        chk("R4", first_ack, 1, "2:1 burst first ack");
        tenure(1,0,1,1, 0,1,0, 1, -1,-1,0,-1);
        chk("R4", first_ack, 1, "burst write first ack");
        tenure(1,1,0,1, 0,1,0, 1, -1,-1,0,-1);
        chk("R4", first_ack, 1, "instruction fetch first ack");
        tenure(1,1,1,0, 1,1,1, 1, -1,-1,0,-1);
        chk("R4", first_ack, 1, "noncacheable first ack");
        chk("R5", int'(first_ack >= WIN), 1, "ack not before retry window");

        // R7: gappy memory
        tenure(1,1,1,1, 3,0,0, 2, -1,-1,0,-1);
        chk("R7", first_ack, 2, "first ack waits for valid");
        chk("R7", n_ack, 4, "gappy burst ack count");

        // R9: error on second beat
        tenure(1,1,1,1, 2,0,0, 1, 2,-1,0,-1);
        chk("R9", n_ack, 1, "acks before error");
        chk("R9", n_err, 1, "error count");

        // R10: retry with live tag mid burst
        tenure(1,1,1,1, 2,0,0, 1, -1,3,0,-1);
        chk("R10", n_ack, 2, "acks before kill");
        chk("R10", n_err, 0, "no error on kill");
        // R10: retry before first ack during forced wait
        tenure(1,1,1,1, 0,1,0, 1, -1,1,0,-1);
        chk("R10", n_ack, 0, "kill during wait");

        // R11: stale tag
        tenure(1,1,1,1, 2,0,0, 1, -1,2,1,-1);
        chk("R11", n_ack, 4, "stale retry ignored");

        // R1: strobe during busy tenure ignored, tag count unchanged
        tenure(1,1,1,1, 0,1,0, 1, -1,-1,0,2);
        chk("R1", n_grant, 1, "no second grant");
        chk("R1", n_ack, 4, "burst intact");
        tenure(1,1,1,1, 2,0,0, 1, -1,2,0,-1);
        chk("R1", n_ack, 1, "tag order after ignored strobe");

        repeat (4) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule